// File: doc/BRIEF.md
# Transmit FIFO DMA Request Generator

This block produces the request line that a level-triggered, demand-mode DMA controller watches when it fills a transmit FIFO. A block transfer is opened with a start strobe that carries the byte count n. The request stays high while bytes are still owed to the FIFO. Each accepted write advances a 1-based transfer index. The request is withdrawn one byte early: on the write of transfer n-1, and on the write of every transfer whose index leaves a remainder of 31 when divided by 32. The early drop lets a slow controller stop cleanly.

After an early drop, a rising edge on acknowledge or on chip select raises the request again. A fast controller may instead move the final byte of the segment before it sees the drop. In that case the request stays low. After a full 32-byte segment, with bytes still outstanding, it waits for a segment-ready strobe that marks FIFO room for the next segment. After the last byte it waits for a new start. While acknowledge is high, every write strobe edge is a FIFO write, whatever the address and chip select are. Without acknowledge, a write is accepted only when chip select is high and the address equals the FIFO address.

Top module: `txdma_req`

## Requirements
- R1: After reset, `drq_o` and `fifo_we_o` are 0.
- R2: A start strobe with a nonzero length makes `drq_o` 1 from the next cycle. A start strobe with length 0 leaves `drq_o` at 0, and later writes do not raise it.
- R3: `fifo_we_o` is 1 in the cycle of a rising edge of `wr_i` when `ack_i` is 1, whatever `cs_i` and `addr_i` are. When `ack_i` is 0, it is 1 only if `cs_i` is 1 and `addr_i` equals FIFO_ADDR. Only accepted writes advance the transfer index.
- R4: The transfer index starts at 1 on a start. An accepted write that is not a drop point keeps `drq_o` at 1.
- R5: The accepted write of transfer n-1 makes `drq_o` 0 from the next cycle.
- R6: The accepted write of any transfer whose index mod 32 equals 31 makes `drq_o` 0 from the next cycle.
- R7: After an early drop, and before the next accepted write, a rising edge on `ack_i` or on `cs_i` makes `drq_o` 1 from the next cycle.
- R8: The accepted write of a transfer whose index is a multiple of 32, when that transfer is not the last, makes `drq_o` 0. `drq_o` then stays 0 through acknowledge edges until `seg_rdy_i` is 1, which raises it the next cycle.
- R9: The accepted write of transfer n makes `drq_o` 0. `drq_o` then stays 0 through acknowledge edges until the next start.
- R10: If an accepted write and a re-arm edge arrive in the same cycle, the write decides the next state, and the edge is discarded.
- R11: A start during a transfer reloads the length and restarts the index at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Block start, samples `len_i` |
| len_i | input | LEN_W | Block length n in bytes |
| seg_rdy_i | input | 1 | FIFO has room for the next 32-byte segment |
| wr_i | input | 1 | Bus write strobe; its rising edge is the event |
| ack_i | input | 1 | DMA acknowledge, level |
| cs_i | input | 1 | Chip select |
| addr_i | input | ADDR_W | Bus address |
| drq_o | output | 1 | Transmit DMA request |
| fifo_we_o | output | 1 | One-cycle FIFO top write pulse |

## Verification
The write that completes a segment can land in the same cycle as the acknowledge edge that would re-arm the request. In that case the write takes the block to the segment pause, and the request must not be raised. The bench provokes this by holding acknowledge low after the early drop on transfer 31. It then raises acknowledge and the write strobe on the same edge. It judges the result by seeing `drq_o` stay low until `seg_rdy_i` is pulsed. It then confirms that the drop on transfer n-1 lands exactly where it should, which proves that the coinciding write was counted.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_HOLD  = 2'd2,
    ST_PAUSE = 2'd3
  } txdma_st_e;
endpackage

// File: rtl/txdma_edge.sv
module txdma_edge #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= sig_i[g];
    end
    assign rise_o[g] = sig_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/txdma_cnt.sv
module txdma_cnt #(
  parameter int LEN_W = 12,
  parameter int SEG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             step_i,
  output logic             last_o,
  output logic             early_o,
  output logic             seg_end_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] idx_q, len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      len_q <= '0;
    end else if (load_i) begin
      idx_q <= ONE;
      len_q <= len_i;
    end else if (step_i) begin
      idx_q <= idx_q + ONE;
    end
  end

  // idx_q is the number of the transfer currently being written
  assign last_o    = (idx_q == len_q);
  assign early_o   = (idx_q == len_q - ONE) || (&idx_q[SEG_W-1:0]);
  assign seg_end_o = (idx_q[SEG_W-1:0] == '0);

  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i |=> idx_q == $past(idx_q) + ONE);
  assert_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> idx_q == ONE);
endmodule

// File: rtl/txdma_fsm.sv
module txdma_fsm
  import txdma_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic len_zero_i,
  input  logic wr_ev_i,
  input  logic rearm_i,
  input  logic seg_rdy_i,
  input  logic last_i,
  input  logic early_i,
  input  logic seg_end_i,
  output logic step_o,
  output logic drq_o
);
  txdma_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (start_i) begin
      st_d = len_zero_i ? ST_IDLE : ST_REQ;
    end else begin
      case (st_q)
        ST_REQ, ST_HOLD: begin
          // write outranks a re-arm edge in the same cycle
          if (wr_ev_i) begin
            if (last_i)         st_d = ST_IDLE;
            else if (seg_end_i) st_d = ST_PAUSE;
            else if (early_i)   st_d = ST_HOLD;
          end else if (st_q == ST_HOLD && rearm_i) begin
            st_d = ST_REQ;
          end
        end
        ST_PAUSE: if (seg_rdy_i) st_d = ST_REQ;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign step_o = wr_ev_i && !start_i && (st_q == ST_REQ || st_q == ST_HOLD);
  assign drq_o  = (st_q == ST_REQ);

  assert_zero_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && len_zero_i |=> !drq_o);
  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !len_zero_i |=> drq_o);
  assert_early_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o && early_i |=> !drq_o);
  assert_last_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o && last_i |=> !drq_o);
  assert_rearm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_HOLD && rearm_i && !wr_ev_i && !start_i |=> drq_o);
  assert_pause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_PAUSE && !seg_rdy_i && !start_i |=> !drq_o);
  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_IDLE && !start_i |=> !drq_o);
endmodule

// File: rtl/txdma_req.sv
module txdma_req #(
  parameter int                LEN_W     = 12,
  parameter int                SEG_W     = 5,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] FIFO_ADDR = 8'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              seg_rdy_i,
  input  logic              wr_i,
  input  logic              ack_i,
  input  logic              cs_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              drq_o,
  output logic              fifo_we_o
);
  localparam int NEDGE = 3;

  logic [NEDGE-1:0] rise;
  logic wr_rise, ack_rise, cs_rise, wr_ev, rearm, step;
  logic last, early, seg_end;

  txdma_edge #(.W(NEDGE)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i ({cs_i, ack_i, wr_i}),
    .rise_o(rise)
  );

  assign wr_rise  = rise[0];
  assign ack_rise = rise[1];
  assign cs_rise  = rise[2];

  // acknowledge selects the FIFO top on its own; otherwise decode address
  assign wr_ev     = wr_rise && (ack_i || (cs_i && addr_i == FIFO_ADDR));
  assign rearm     = ack_rise || cs_rise;
  assign fifo_we_o = wr_ev;

  txdma_cnt #(.LEN_W(LEN_W), .SEG_W(SEG_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start_i),
    .len_i    (len_i),
    .step_i   (step),
    .last_o   (last),
    .early_o  (early),
    .seg_end_o(seg_end)
  );

  txdma_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .len_zero_i(len_i == '0),
    .wr_ev_i   (wr_ev),
    .rearm_i   (rearm),
    .seg_rdy_i (seg_rdy_i),
    .last_i    (last),
    .early_i   (early),
    .seg_end_i (seg_end),
    .step_o    (step),
    .drq_o     (drq_o)
  );

  always_comb begin
    if (rst_ni && fifo_we_o)
      assert_we_strobe_R3: assert (wr_i && (ack_i || cs_i));
  end
endmodule

// File: tb/txdma_req_test.sv
module txdma_req_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [11:0] len = '0;
  logic seg_rdy = 1'b0;
  logic wr = 1'b0;
  logic ack = 1'b1;
  logic cs = 1'b0;
  logic [7:0] addr = 8'h22;
  logic drq, we;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [7:0] FADDR = 8'h10;
  localparam logic [7:0] BADDR = 8'h22;

  always #4 clk = ~clk;

  txdma_req uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_i(len),
    .seg_rdy_i(seg_rdy), .wr_i(wr), .ack_i(ack), .cs_i(cs),
    .addr_i(addr), .drq_o(drq), .fifo_we_o(we)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_start(input int n);
    @(negedge clk); start = 1'b1; len = 12'(n);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wr_pulse(input logic a, input logic c, input logic [7:0] ad,
                          output logic we_seen);
    @(negedge clk); ack = a; cs = c; addr = ad; wr = 1'b1;
    #1 we_seen = we;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic ack_pulse();
    @(negedge clk); ack = 1'b0;
    @(negedge clk); ack = 1'b1;
    @(negedge clk);
  endtask

  task automatic seg_pulse();
    @(negedge clk); seg_rdy = 1'b1;
    @(negedge clk); seg_rdy = 1'b0;
  endtask

  task automatic run_block(input int n, input bit fast);
    logic w;
    do_start(n);
    check("R2 start", drq, 1'b1);
    for (int i = 1; i <= n; i++) begin
      wr_pulse(1'b1, 1'b0, BADDR, w);
      check("R3 ack write", w, 1'b1);
      if (i == n) begin
        check("R9 last", drq, 1'b0);
        ack_pulse();
        check("R9 ack after last", drq, 1'b0);
      end else if (i % 32 == 0) begin
        check("R8 seg full", drq, 1'b0);
        ack_pulse();
        check("R8 ack in pause", drq, 1'b0);
        seg_pulse();
        check("R8 seg ready", drq, 1'b1);
      end else if (i == n - 1) begin
        check("R5 n-1 drop", drq, 1'b0);
        if (!fast) begin ack_pulse(); check("R7 rearm", drq, 1'b1); end
      end else if (i % 32 == 31) begin
        check("R6 mod31 drop", drq, 1'b0);
        if (!fast) begin ack_pulse(); check("R7 rearm", drq, 1'b1); end
      end else begin
        check("R4 keep", drq, 1'b1);
      end
    end
  endtask

  task automatic t_reset();
    check("R1 drq", drq, 1'b0);
    check("R1 we", we, 1'b0);
  endtask

  task automatic t_zero_len();
    logic w;
    do_start(0);
    check("R2 zero len", drq, 1'b0);
    wr_pulse(1'b1, 1'b0, BADDR, w);
    check("R2 zero len write", drq, 1'b0);
  endtask

  task automatic t_select();
    logic w;
    do_start(3);
    wr_pulse(1'b0, 1'b1, BADDR, w);
    check("R3 bad addr no we", w, 1'b0);
    check("R3 bad addr drq", drq, 1'b1);
    wr_pulse(1'b1, 1'b0, BADDR, w);
    check("R3 ack ignores addr", w, 1'b1);
    check("R4 idx1 keep", drq, 1'b1);
    wr_pulse(1'b0, 1'b1, FADDR, w);
    check("R3 cs addr write", w, 1'b1);
    check("R5 counted drop", drq, 1'b0);
    @(negedge clk); cs = 1'b0; ack = 1'b0;
    @(negedge clk); cs = 1'b1;
    @(negedge clk);
    check("R7 cs rearm", drq, 1'b1);
    wr_pulse(1'b1, 1'b0, BADDR, w);
    check("R9 last after cs", drq, 1'b0);
  endtask

  task automatic t_collide();
    logic w;
    do_start(40);
    for (int i = 1; i <= 30; i++) wr_pulse(1'b1, 1'b0, BADDR, w);
    check("R4 before 31", drq, 1'b1);
    wr_pulse(1'b1, 1'b0, BADDR, w);
    check("R6 drop 31", drq, 1'b0);
    @(negedge clk); ack = 1'b0;
    @(negedge clk); ack = 1'b1; wr = 1'b1;
    #1 check("R10 we", we, 1'b1);
    @(negedge clk); wr = 1'b0;
    check("R10 write wins", drq, 1'b0);
    @(negedge clk);
    check("R10 stays low", drq, 1'b0);
    seg_pulse();
    check("R8 resume", drq, 1'b1);
    for (int i = 33; i <= 38; i++) wr_pulse(1'b1, 1'b0, BADDR, w);
    check("R10 index kept", drq, 1'b1);
    wr_pulse(1'b1, 1'b0, BADDR, w);
    check("R5 drop 39", drq, 1'b0);
  endtask

  task automatic t_restart();
    logic w;
    do_start(40);
    for (int i = 1; i <= 5; i++) wr_pulse(1'b1, 1'b0, BADDR, w);
    check("R11 mid", drq, 1'b1);
    do_start(2);
    check("R11 restart", drq, 1'b1);
    wr_pulse(1'b1, 1'b0, BADDR, w);
    check("R11 new len drop", drq, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_len();
    run_block(1, 1'b0);
    run_block(2, 1'b1);
    run_block(5, 1'b0);
    run_block(32, 1'b0);
    run_block(70, 1'b0);
    run_block(70, 1'b1);
    t_select();
    t_collide();
    t_restart();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule